// File: doc/BRIEF.md
# Two-Class Dual-Issue Controller

This block sits at the issue point of a short in-order pipeline and decides, once per pipeline clock, which of the two instructions in the current fetch pair may leave for execution. Each instruction arrives with a class bit that was set when it was fetched. The bit says whether the instruction is a floating-point ALU operation or belongs to the other class. The controller never decodes opcodes. One instruction of each class may go in the same cycle, so the two slots never need a dependency check against each other.

Each slot also carries a flag that marks it as needing the long-latency unit of its own class. For the floating-point class that unit is divide/square-root, and for the other class it is integer multiply/divide. While that unit reports busy, the instruction waits. Issue is strictly in order. A blocked older instruction holds the younger one back, and the controller reports a slip. A pair that starts on its second word, for example after a branch to an odd word, offers only its younger slot. A two-bit consumed count tells the fetch buffer how far to advance. All outputs are registered, so they appear one clock after the inputs are sampled.

Top module: `dual_issue_ctl`

## Requirements
- R1: Bit 0 of every per-slot vector is the older instruction (lower word of the aligned pair) and bit 1 is the younger. A class bit of 1 marks a floating-point ALU operation, and 0 marks any other instruction.
- R2: Both slots issue in the same cycle only when their class bits differ.
- R3: When both slots are valid, ready and of the same class, only slot 0 issues.
- R4: A slot whose long-latency flag is set does not issue while the busy input for its own class's unit is 1. The class bit selects the unit: 1 selects FP divide/sqrt and 0 selects integer multiply/divide. The busy input of the other class's unit has no effect on that slot.
- R5: Slot 1 never issues while slot 0 is valid and not issuing.
- R6: When slot 0 is invalid and slot 1 is valid and ready, slot 1 issues alone.
- R7: An invalid slot never issues.
- R8: Slip is 1 exactly when the oldest valid slot is blocked by a busy unit. It is 0 when no slot is valid, and 0 when the younger slot is held only because it shares the older slot's class.
- R9: The consumed count equals the number of issue enables that are set (0, 1 or 2).
- R10: Outputs are registered. A decision appears one clock after its inputs are sampled, and reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 2 | Slot holds an instruction (bit 0 older) |
| slot_is_fp | input | 2 | Pre-decoded class: 1 = FP ALU operation |
| slot_long | input | 2 | Slot needs its class's long-latency unit |
| fp_divsqrt_busy | input | 1 | FP divide/square-root unit busy |
| int_muldiv_busy | input | 1 | Integer multiply/divide unit busy |
| issue_en | output | 2 | Per-slot issue enable |
| slip | output | 1 | Oldest valid instruction stalled on a busy unit |
| consumed | output | 2 | Instructions taken from the fetch pair |

## Verification
The checker assumes that every input is a plain 0/1 value and is steady across each sampling edge. It also assumes that the fetch buffer presents a new pair only in the way the consumed count allows, so bit 0 is always the older instruction. The stimulus drives every input on the falling edge and sweeps all 256 combinations of valid, class, long-latency and busy bits. That covers every slot arrangement, including a pair that offers only its second word. It reads the registered result one full clock later.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  parameter int unsigned NUM_SLOTS = 2;
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);

  typedef enum logic {
    CLS_OTHER = 1'b0,
    CLS_FPALU = 1'b1
  } issue_class_e;

  typedef struct packed {
    logic         valid;
    issue_class_e cls;
    logic         needs_long;
  } slot_info_t;
endpackage

// File: rtl/dual_issue_slot_eval.sv
module dual_issue_slot_eval
  import dual_issue_pkg::*;
(
  input  slot_info_t slot,
  input  logic       fp_unit_busy,
  input  logic       int_unit_busy,
  output logic       ready,
  output logic       blocked
);
  logic unit_busy;

  always_comb begin
    unit_busy = (slot.cls == CLS_FPALU) ? fp_unit_busy : int_unit_busy;
    blocked   = slot.valid & slot.needs_long & unit_busy;
    ready     = slot.valid & ~blocked;
  end
endmodule

// File: rtl/dual_issue_pair_arb.sv
module dual_issue_pair_arb
  import dual_issue_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  slot_info_t old_slot,
  input  slot_info_t young_slot,
  input  logic       old_ready,
  input  logic       old_blocked,
  input  logic       young_ready,
  input  logic       young_blocked,
  output logic [1:0] grant,
  output logic       stall,
  output logic [W-1:0] taken
);
  logic classes_differ;
  logic path_clear;

  always_comb begin
    classes_differ = (old_slot.cls != young_slot.cls);
    // the younger slot may pass only if nothing older remains behind it
    path_clear     = ~old_slot.valid | (old_ready & classes_differ);
    grant[0]       = old_ready;
    grant[1]       = young_ready & path_clear;
    stall          = old_slot.valid ? old_blocked : young_blocked;
    taken          = W'(grant[0]) + W'(grant[1]);
  end
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dual_issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       slot_valid,
  input  logic [1:0]       slot_is_fp,
  input  logic [1:0]       slot_long,
  input  logic             fp_divsqrt_busy,
  input  logic             int_muldiv_busy,
  output logic [1:0]       issue_en,
  output logic             slip,
  output logic [CNT_W-1:0] consumed
);
  slot_info_t       info  [NUM_SLOTS];
  logic [1:0]       rdy;
  logic [1:0]       blk;
  logic [1:0]       grant_d;
  logic             stall_d;
  logic [CNT_W-1:0] taken_d;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign info[s].valid      = slot_valid[s];
    assign info[s].cls        = issue_class_e'(slot_is_fp[s]);
    assign info[s].needs_long = slot_long[s];

    dual_issue_slot_eval u_eval (
      .slot          (info[s]),
      .fp_unit_busy  (fp_divsqrt_busy),
      .int_unit_busy (int_muldiv_busy),
      .ready         (rdy[s]),
      .blocked       (blk[s])
    );
  end

  dual_issue_pair_arb #(.W(CNT_W)) u_arb (
    .old_slot      (info[0]),
    .young_slot    (info[1]),
    .old_ready     (rdy[0]),
    .old_blocked   (blk[0]),
    .young_ready   (rdy[1]),
    .young_blocked (blk[1]),
    .grant         (grant_d),
    .stall         (stall_d),
    .taken         (taken_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_en <= '0;
      slip     <= 1'b0;
      consumed <= '0;
    end else begin
      issue_en <= grant_d;
      slip     <= stall_d;
      consumed <= taken_d;
    end
  end
endmodule

// File: rtl/dual_issue_ctl_chk.sv
module dual_issue_ctl_chk
  import dual_issue_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       slot_valid,
  input logic [1:0]       slot_is_fp,
  input logic [1:0]       slot_long,
  input logic             fp_divsqrt_busy,
  input logic             int_muldiv_busy,
  input logic [1:0]       issue_en,
  input logic             slip,
  input logic [CNT_W-1:0] consumed
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r2_pair_classes_differ: assert property (@(posedge clk) disable iff (rst)
    (armed && issue_en == 2'b11) |-> ($past(slot_is_fp[0]) != $past(slot_is_fp[1])));

  a_r5_no_overtake: assert property (@(posedge clk) disable iff (rst)
    (armed && issue_en[1] && $past(slot_valid[0])) |-> issue_en[0]);

  a_r7_valid_only: assert property (@(posedge clk) disable iff (rst)
    (armed && issue_en[0]) |-> $past(slot_valid[0]));

  a_r7_valid_only_young: assert property (@(posedge clk) disable iff (rst)
    (armed && issue_en[1]) |-> $past(slot_valid[1]));

  a_r4_busy_blocks_old: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(slot_long[0]) &&
     ($past(slot_is_fp[0]) ? $past(fp_divsqrt_busy) : $past(int_muldiv_busy)))
    |-> !issue_en[0]);

  a_r8_slip_means_none: assert property (@(posedge clk) disable iff (rst)
    slip |-> (issue_en == 2'b00));

  a_r9_count_matches: assert property (@(posedge clk) disable iff (rst)
    consumed == CNT_W'($countones(issue_en)));
endmodule

bind dual_issue_ctl dual_issue_ctl_chk u_chk (.*);

// File: tb/dual_issue_ctl_tb_top.sv
module dual_issue_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] slot_valid, slot_is_fp, slot_long;
  logic       fp_divsqrt_busy, int_muldiv_busy;
  logic [1:0] issue_en;
  logic       slip;
  logic [1:0] consumed;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_ctl dut_i (
    .clk(clk), .rst(rst),
    .slot_valid(slot_valid), .slot_is_fp(slot_is_fp), .slot_long(slot_long),
    .fp_divsqrt_busy(fp_divsqrt_busy), .int_muldiv_busy(int_muldiv_busy),
    .issue_en(issue_en), .slip(slip), .consumed(consumed)
  );

  task automatic check(string req, int act, int exp, int idx);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s case=%0d actual=%0d expected=%0d", req, idx, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1;
    slot_valid = 2'b11; slot_is_fp = 2'b01; slot_long = 2'b00;
    fp_divsqrt_busy = 1'b0; int_muldiv_busy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 reset issue", issue_en, 0, -1);
    check("R10 reset slip", slip, 0, -1);
    check("R10 reset count", consumed, 0, -1);
    rst = 1'b0;

    for (int i = 0; i < 256; i++) begin
      logic v0, v1, c0, c1, l0, l1, fb, mb;
      logic ok0, ok1, bl0, bl1, e0, e1, sl;
      {mb, fb, l1, l0, c1, c0, v1, v0} = 8'(i);
      slot_valid = {v1, v0}; slot_is_fp = {c1, c0}; slot_long = {l1, l0};
      fp_divsqrt_busy = fb; int_muldiv_busy = mb;
      // R1/R4: class 1 uses FP unit busy, class 0 uses int unit busy
      bl0 = v0 & l0 & (c0 ? fb : mb);
      bl1 = v1 & l1 & (c1 ? fb : mb);
      ok0 = v0 & ~bl0;
      ok1 = v1 & ~bl1;
      e0 = ok0;
      // R2/R3/R5/R6
      e1 = ok1 & (~v0 | (e0 & (c0 ^ c1)));
      sl = v0 ? bl0 : bl1;
      @(posedge clk);
      @(negedge clk);
      // R10: result visible one clock after sampling
      check("R4 R7 slot0 issue", issue_en[0], e0, i);
      if (v0 & v1 & ok0 & ok1 & (c0 == c1))
        check("R3 same class younger held", issue_en[1], 0, i);
      else if (!v0)
        check("R6 lone younger slot", issue_en[1], e1, i);
      else
        check("R2 R5 slot1 issue", issue_en[1], e1, i);
      check("R8 slip", slip, sl, i);
      check("R9 consumed", consumed, e0 + e1, i);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule